// File: doc/BRIEF.md
# Up/Down PWM Timer with Two Compare Channels

This block is a synchronous timer that counts from zero up to a programmable TOP and back down again. On that triangle it builds symmetric pulse-width modulated waveforms on two compare channels. A divider picks how often the counter may step. The divider never creates a second clock. It raises a one-cycle enable, and every register in the timer advances only in a cycle where that enable is high.

Each channel holds its compare value in two stages. Software writes a buffer. The active compare value is loaded from that buffer at a fixed point of the triangle: at TOP in the first update mode, or at zero in the second. A new duty cycle therefore never breaks a period in half. Each channel has a sticky match flag and its own output polarity. A sticky overflow flag marks every turn at zero. Software configures the timer through a single write port and clears flags by writing ones.

Top module: `pwm_timer`

## Requirements
- R1: Control bits [2:0] select the step rate. Code 1 steps every cycle. Codes 2, 3, 4 and 5 step once every 8, 64, 256 and 1024 cycles, on the cycles where a free-running cycle count that starts at zero after reset, taken modulo the ratio, equals the ratio minus one. Codes 0, 6 and 7 stop the timer, and the counter, flags and outputs then keep their values.
- R2: On each step the counter moves by one and turns around at the ends without repeating an end value. Counting up, a counter at or above TOP turns down and decrements. Counting down, a counter at zero turns up to 1, or stays at 0 when TOP is 0.
- R3: With control bit 3 clear, a channel's active compare value is loaded from its buffer on each step taken while the counter equals TOP.
- R4: With control bit 3 set, the active compare value is loaded from the buffer on each step taken while the counter is zero.
- R5: The overflow flag is set on each step taken while the counter is zero. It then stays set until a write of a one to bit 0 of the flag-clear address, and a set in the same cycle wins over the clear.
- R6: A channel's match flag is set on each step taken while the counter equals its active compare value. Writing a one to flag-clear bit 1 (channel A) or bit 2 (channel B) clears it, and a set wins over a clear in the same cycle.
- R7: On a non-inverted channel, a match while counting up drives the output low and a match while counting down drives it high. The output changes one cycle after the matching step.
- R8: A non-inverted channel whose active compare value is zero drives its output low constantly. One whose active compare value is TOP or above drives it high constantly.
- R9: Control bit 4 (channel A) and bit 5 (channel B) invert the channel output in every case, including both constant cases.
- R10: Write addresses are 0 for TOP, 1 for buffer A, 2 for buffer B, 3 for control and 4 for flag clear. After reset the counter, flags, compare values and control are zero, TOP is all ones, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| cnt_o | output | CNT_W | Current counter value |
| ovf_flag_o | output | 1 | Sticky turn-at-zero flag |
| cmp_flag_o | output | 2 | Sticky match flags, bit 0 for channel A and bit 1 for channel B |
| pwm_o | output | 2 | Waveform outputs, bit 0 for channel A and bit 1 for channel B |

## Verification
A wrong divider phase or a wrong direction bit shows at the next step in `cnt_o`. That is at most 1024 cycles away, and the bench compares the counter in every cycle. An active compare value loaded at the wrong end of the triangle cannot be seen directly. It first shows as an output edge displaced in the following half period, and the cycle-by-cycle comparison catches that. A wrong level register or a wrong constant-level decode shows on `pwm_o` in the cycle after the matching step, or at once in the constant cases. A flag that fails to stick shows in the cycle after a clear write that should not have cleared it.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int unsigned SEL_W = 3;

  // write addresses
  localparam logic [SEL_W-1:0] ADDR_TOP   = 3'd0;
  localparam logic [SEL_W-1:0] ADDR_BUF_A = 3'd1;
  localparam logic [SEL_W-1:0] ADDR_BUF_B = 3'd2;
  localparam logic [SEL_W-1:0] ADDR_CTRL  = 3'd3;
  localparam logic [SEL_W-1:0] ADDR_FCLR  = 3'd4;

  // step-rate select codes
  localparam logic [2:0] RATE_STOP = 3'd0;
  localparam logic [2:0] RATE_1    = 3'd1;
  localparam logic [2:0] RATE_8    = 3'd2;
  localparam logic [2:0] RATE_64   = 3'd3;
  localparam logic [2:0] RATE_256  = 3'd4;
  localparam logic [2:0] RATE_1024 = 3'd5;

  typedef enum logic {
    LOAD_AT_TOP    = 1'b0,
    LOAD_AT_BOTTOM = 1'b1
  } load_pt_e;

  typedef struct packed {
    logic     inv_b;   // bit 5
    logic     inv_a;   // bit 4
    load_pt_e load_pt; // bit 3
    logic [2:0] rate;  // bits 2:0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate,
  output logic       tick
);
  import pwm_timer_pkg::*;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;
  logic [3:0]       shift;
  logic             run;

  always_comb begin
    pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // ratio = 2**shift, tick on the last cycle of each window
  always_comb begin
    run   = 1'b1;
    shift = 4'd0;
    case (rate)
      RATE_1:    shift = 4'd0;
      RATE_8:    shift = 4'd3;
      RATE_64:   shift = 4'd6;
      RATE_256:  shift = 4'd8;
      RATE_1024: shift = 4'd10;
      default:   run   = 1'b0;
    endcase
    mask = (PRE_W'(1) << shift) - PRE_W'(1);
    tick = run && ((pre_q & mask) == mask);
  end

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         dir_down
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (tick) begin
      if (!down_q) begin
        if (cnt_q >= top) begin
          down_d = 1'b1;
          if (cnt_q != '0) cnt_d = cnt_q - W'(1);
        end else begin
          cnt_d = cnt_q + W'(1);
        end
      end else begin
        if (cnt_q == '0) begin
          if (top != '0) begin
            down_d = 1'b0;
            cnt_d  = W'(1);
          end
        end else begin
          cnt_d = cnt_q - W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt      = cnt_q;
  assign dir_down = down_q;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] cnt,
  input  logic         dir_down,
  input  logic [W-1:0] top,
  input  logic [W-1:0] buf_val,
  input  logic         inv,
  input  logic         flag_clr,
  output logic         match_flag,
  output logic         pwm
);

  logic [W-1:0] act_q, act_d;
  logic         lvl_q, lvl_d;
  logic         flag_q, flag_d;
  logic         hit;
  logic         level;

  always_comb begin
    hit    = tick && (cnt == act_q);
    act_d  = load ? buf_val : act_q;
    lvl_d  = hit ? dir_down : lvl_q;
    flag_d = hit | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
    end
  end

  // end values force a constant level
  always_comb begin
    if (act_q == '0)       level = 1'b0;
    else if (act_q >= top) level = 1'b1;
    else                   level = lvl_q;
    pwm = level ^ inv;
  end

  assign match_flag = flag_q;

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_flag_o,
  output logic [1:0]       cmp_flag_o,
  output logic [1:0]       pwm_o
);
  import pwm_timer_pkg::*;

  localparam int unsigned NUM_CH = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // configuration registers
  logic [CNT_W-1:0] top_q, top_d;
  logic [CNT_W-1:0] buf_q [NUM_CH];
  logic [CNT_W-1:0] buf_d [NUM_CH];
  ctrl_t            ctrl_q, ctrl_d;
  logic             ovf_q, ovf_d;
  logic             fclr;
  logic             ovf_clr;

  logic             tick;
  logic             load;
  logic [CNT_W-1:0] cnt;
  logic             dir_down;
  logic [NUM_CH-1:0] inv;

  always_comb begin
    top_d  = top_q;
    ctrl_d = ctrl_q;
    for (int i = 0; i < NUM_CH; i++) buf_d[i] = buf_q[i];
    if (wr_en) begin
      case (wr_sel)
        ADDR_TOP:   top_d    = wr_data;
        ADDR_BUF_A: buf_d[0] = wr_data;
        ADDR_BUF_B: buf_d[1] = wr_data;
        ADDR_CTRL:  ctrl_d   = ctrl_t'(wr_data[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    fclr    = wr_en && (wr_sel == ADDR_FCLR);
    ovf_clr = fclr && wr_data[0];
    ovf_d   = (tick && (cnt == '0)) | (ovf_q & ~ovf_clr);
    if (ctrl_q.load_pt == LOAD_AT_TOP) load = tick && (cnt == top_q);
    else                               load = tick && (cnt == '0);
    inv = {ctrl_q.inv_b, ctrl_q.inv_a};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      top_q  <= '1;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) buf_q[i] <= '0;
    end else begin
      top_q  <= top_d;
      ctrl_q <= ctrl_d;
      ovf_q  <= ovf_d;
      for (int i = 0; i < NUM_CH; i++) buf_q[i] <= buf_d[i];
    end
  end

  pwm_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rate  (ctrl_q.rate),
    .tick  (tick)
  );

  pwm_updown_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .top      (top_q),
    .cnt      (cnt),
    .dir_down (dir_down)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .tick       (tick),
      .load       (load),
      .cnt        (cnt),
      .dir_down   (dir_down),
      .top        (top_q),
      .buf_val    (buf_q[g]),
      .inv        (inv[g]),
      .flag_clr   (fclr && wr_data[g+1]),
      .match_flag (cmp_flag_o[g]),
      .pwm        (pwm_o[g])
    );
  end

  assign cnt_o      = cnt;
  assign ovf_flag_o = ovf_q;

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic         ovf_clr,
  input logic [W-1:0] cnt,
  input logic         ovf_flag,
  input logic [1:0]   pwm
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: no step, no counter movement
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !tick |=> $stable(cnt));

  // R2: a step moves the counter by at most one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && tick |=> (cnt == $past(cnt) + W'(1)) || (cnt == $past(cnt) - W'(1))
                        || (cnt == $past(cnt)));

  // R5: a step at zero raises the overflow flag
  a_r5_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && tick && (cnt == '0) |=> ovf_flag);

  // R5: the flag stays until explicitly cleared
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && ovf_flag && !ovf_clr |=> ovf_flag);

  // R7: outputs move only after a step or a write
  a_r7_pwm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !tick && !wr_en |=> $stable(pwm));

endmodule

bind pwm_timer pwm_timer_checker #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .wr_en    (wr_en),
  .ovf_clr  (ovf_clr),
  .cnt      (cnt_o),
  .ovf_flag (ovf_flag_o),
  .pwm      (pwm_o)
);

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic [15:0] cnt_o;
  logic        ovf_flag_o;
  logic [1:0]  cmp_flag_o;
  logic [1:0]  pwm_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  pwm_timer u_pwm_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .cnt_o      (cnt_o),
    .ovf_flag_o (ovf_flag_o),
    .cmp_flag_o (cmp_flag_o),
    .pwm_o      (pwm_o)
  );

  typedef struct packed {
    logic [15:0] cnt;
    logic        ovf;
    logic [1:0]  cf;
    logic [1:0]  pwm;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // reference model built from the requirements (R1..R10)
  function automatic bit rate_tick(input logic [9:0] p, input logic [2:0] s);
    case (s)
      3'd1: return 1'b1;
      3'd2: return p[2:0] == 3'h7;
      3'd3: return p[5:0] == 6'h3f;
      3'd4: return p[7:0] == 8'hff;
      3'd5: return p == 10'h3ff;
      default: return 1'b0;
    endcase
  endfunction

  logic [9:0]  m_pre;
  logic [15:0] m_cnt, m_top;
  logic        m_down, m_ovf, m_s1, m_s2;
  logic [15:0] m_act [2];
  logic [15:0] m_buf [2];
  logic        m_lvl [2];
  logic        m_cf  [2];
  logic [5:0]  m_ctrl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = '0; m_cnt = '0; m_top = '1; m_down = 1'b0; m_ovf = 1'b0;
      m_ctrl = '0; m_s1 = 1'b0; m_s2 = 1'b0;
      for (int i = 0; i < 2; i++) begin
        m_act[i] = '0; m_buf[i] = '0; m_lvl[i] = 1'b0; m_cf[i] = 1'b0;
      end
    end else if (!m_s2) begin
      m_s2 = m_s1;
      m_s1 = 1'b1;
    end else begin
      bit tk, ld, fc;
      logic [15:0] oc;
      logic od;
      exp_t e;
      tk = rate_tick(m_pre, m_ctrl[2:0]);
      oc = m_cnt; od = m_down;
      fc = wr_en && (wr_sel == 3'd4);
      ld = tk && (m_ctrl[3] ? (oc == 16'd0) : (oc == m_top));
      if (tk) begin
        if (!od) begin
          if (oc >= m_top) begin m_down = 1'b1; if (oc != 0) m_cnt = oc - 16'd1; end
          else m_cnt = oc + 16'd1;
        end else begin
          if (oc == 0) begin if (m_top != 0) begin m_down = 1'b0; m_cnt = 16'd1; end end
          else m_cnt = oc - 16'd1;
        end
      end
      for (int i = 0; i < 2; i++) begin
        bit hit;
        hit = tk && (oc == m_act[i]);
        if (hit) m_lvl[i] = od;
        m_cf[i] = hit | (m_cf[i] & !(fc && wr_data[i+1]));
        if (ld) m_act[i] = m_buf[i];
      end
      m_ovf = (tk && oc == 16'd0) | (m_ovf & !(fc && wr_data[0]));
      if (wr_en) begin
        case (wr_sel)
          3'd0: m_top = wr_data;
          3'd1: m_buf[0] = wr_data;
          3'd2: m_buf[1] = wr_data;
          3'd3: m_ctrl = wr_data[5:0];
          default: ;
        endcase
      end
      m_pre = m_pre + 10'd1;
      e.cnt = m_cnt; e.ovf = m_ovf; e.cf = {m_cf[1], m_cf[0]};
      for (int i = 0; i < 2; i++) begin
        logic l;
        if (m_act[i] == 0) l = 1'b0;
        else if (m_act[i] >= m_top) l = 1'b1;
        else l = m_lvl[i];
        e.pwm[i] = l ^ m_ctrl[4+i];
      end
      exp_q.push_back(e);
    end
  end

  // monitor: compare each produced result against the queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(cnt_o == e.cnt, "R2 counter (R1 rate)", 32'(cnt_o), 32'(e.cnt));
      chk(ovf_flag_o == e.ovf, "R5 overflow flag", 32'(ovf_flag_o), 32'(e.ovf));
      chk(cmp_flag_o == e.cf, "R6 match flags", 32'(cmp_flag_o), 32'(e.cf));
      chk(pwm_o == e.pwm, "R7 waveform (loads R3 R4, polarity R9)", 32'(pwm_o), 32'(e.pwm));
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run(4);
    // R10 reset state
    chk(cnt_o == 16'd0, "R10 reset counter", 32'(cnt_o), 0);
    chk(ovf_flag_o == 1'b0, "R10 reset overflow", 32'(ovf_flag_o), 0);
    chk(cmp_flag_o == 2'b00, "R10 reset match flags", 32'(cmp_flag_o), 0);
    chk(pwm_o == 2'b00, "R10 reset outputs", 32'(pwm_o), 0);

    // R3 load at TOP, every-cycle rate
    wr(3'd0, 16'd10); wr(3'd1, 16'd4); wr(3'd2, 16'd7);
    wr(3'd3, 16'h0001);
    run(80);

    // R1 stop code holds the counter
    wr(3'd3, 16'h0000);
    held = cnt_o;
    run(40);
    chk(cnt_o == held, "R1 stopped counter holds", 32'(cnt_o), 32'(held));

    // R9 channel A inverted
    wr(3'd3, 16'h0011);
    run(60);

    // R8 constant levels at the end values
    wr(3'd1, 16'd0); wr(3'd2, 16'd10); wr(3'd3, 16'h0001);
    run(30);
    for (int k = 0; k < 25; k++) begin
      chk(pwm_o[0] == 1'b0, "R8 zero compare low", 32'(pwm_o[0]), 0);
      chk(pwm_o[1] == 1'b1, "R8 TOP compare high", 32'(pwm_o[1]), 1);
      run(1);
    end
    // R9 both inverted in the constant cases
    wr(3'd3, 16'h0031);
    for (int k = 0; k < 12; k++) begin
      chk(pwm_o == 2'b01, "R9 inverted constants", 32'(pwm_o), 1);
      run(1);
    end

    // R4 load at zero, rate 8
    wr(3'd1, 16'd3); wr(3'd2, 16'd8); wr(3'd3, 16'h000A);
    run(400);
    // R6 R5 clear by writing ones
    wr(3'd4, 16'h0007);
    run(50);
    wr(3'd4, 16'h0002);
    run(50);

    // R1 slower rates
    wr(3'd0, 16'd5); wr(3'd3, 16'h0013);
    run(1500);
    wr(3'd0, 16'd3); wr(3'd1, 16'd1); wr(3'd2, 16'd2); wr(3'd3, 16'h0024);
    run(2500);
    wr(3'd0, 16'd2); wr(3'd3, 16'h0005);
    run(6000);

    // R2 TOP lowered below the counter while counting up
    wr(3'd0, 16'd20); wr(3'd1, 16'd5); wr(3'd2, 16'd15); wr(3'd3, 16'h0001);
    run(15);
    wr(3'd0, 16'd6);
    run(60);

    // R1 unused rate code stops the timer
    wr(3'd3, 16'h0007);
    held = cnt_o;
    run(30);
    chk(cnt_o == held, "R1 unused code holds", 32'(cnt_o), 32'(held));

    run(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule